// File: doc/BRIEF.md
# Raster-Op Pixel Mixer

The block combines one pixel per request for a 2-D drawing engine. Each request carries a monochrome mix bit, a host data word, a screen-read word and the current destination value. A per-pixel choice between a foreground and a background mix register decides two things: where the source colour comes from, and which of sixteen boolean functions combines that source with the destination. A compare stage can then suppress the write, depending on whether the source matches a compare colour. The mixed result is merged with the old destination under a write mask.

The block can also derive the monochrome bit from the screen-read word through a read mask. This serves pattern and bitmap expansion from video memory. Pixel depth is 8, 16 or 32 bits.

Timing is one register stage. A valid request produces a result with a write strobe on the next cycle. The address generator and the memory port sit outside the block.

Top module: `rop_pixel_mixer`

## Requirements
- R1: The foreground mix register is used when the effective mix bit is 1, and the background mix register when it is 0. The effective mix bit is `mix_bit`, or the screen-derived bit when `mono_from_screen` is 1.
- R2: Bits 6:5 of the selected mix register pick the source: 0 is the background colour, 1 the foreground colour, 2 host data, 3 the screen-read word.
- R3: Bits 3:0 of the selected mix register pick the function. Codes 0 to 7 give ~D, all zeros, all ones, D, ~S, S^D, ~(S^D) and S.
- R4: Codes 8 to 15 give ~(S&D), ~S|D, S|~D, S|D, S&D, S&~D, ~S&D and ~(S|D).
- R5: The compare mode gates the write. With `cmp_mode` 2, `out_we` is 1 only when the source differs from the compare colour. With mode 3, it is 1 only when they are equal. With modes 0 and 1, `out_we` always follows a valid request.
- R6: `out_data` = (mixed & `write_mask`) | (`dest_data` & ~`write_mask`).
- R7: The screen-derived mono bit is 1 exactly when (`screen_data` & read mask) equals the read mask. It is presented on `out_mono` with the result.
- R8: The pixel depth is set by `depth`: 0 is 8 bits, 1 is 16 bits, 2 and 3 are 32 bits. At 8 bits the read mask, compare colour and source used in the compare are cut to bits 7:0, and at 16 bits to bits 15:0.
- R9: Timing is one cycle. `out_valid` follows `in_valid` one cycle later, and `out_we` is never 1 without `out_valid`. While `rst_n` is low (synchronous reset), `out_valid`, `out_we`, `out_mono` and `out_data` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel request present |
| mix_bit | input | 1 | Monochrome mix bit from the host |
| mono_from_screen | input | 1 | Use the screen-derived bit instead of mix_bit |
| fg_mix | input | 8 | Foreground mix register (6:5 source, 3:0 function) |
| bg_mix | input | 8 | Background mix register (6:5 source, 3:0 function) |
| cmp_mode | input | 2 | Colour compare mode |
| depth | input | 2 | Pixel depth select |
| fg_color | input | PIX_W | Foreground colour |
| bg_color | input | PIX_W | Background colour |
| host_data | input | PIX_W | Host data word |
| screen_data | input | PIX_W | Screen-read word |
| dest_data | input | PIX_W | Current destination value |
| cmp_color | input | PIX_W | Compare colour |
| write_mask | input | PIX_W | Bit-plane write mask |
| read_mask | input | PIX_W | Read mask for mono conversion |
| out_valid | output | 1 | Result present |
| out_we | output | 1 | Write strobe for the result |
| out_data | output | PIX_W | Word to write |
| out_mono | output | 1 | Screen-derived mono bit |

## Verification
The bench runs every function code against one source and destination pair that exercises all four bit combinations. A swapped or inverted code therefore shows up as a wrong word.

Compare modes 2 and 3 are driven with equal and unequal colours. A gate with the sense reversed writes exactly the pixels that should be skipped.

At 8-bit depth, the compare colour and read mask carry junk in their upper bits. A design that skips the truncation drops writes and reports a mono bit of 0.

Partial write masks and screen-derived mix bits are also checked. A merge that ignores the mask, or a mix selection that always uses `mix_bit`, corrupts the preserved bits or picks the wrong register.

// File: rtl/rop_pkg.sv
// Package: shared encodings for the raster-op pixel mixer.
// Assumes mix registers place source select in bits 6:5 and function in 3:0.
package rop_pkg;
    typedef enum logic [1:0] {
        SRC_BG     = 2'd0,
        SRC_FG     = 2'd1,
        SRC_HOST   = 2'd2,
        SRC_SCREEN = 2'd3
    } rop_src_e;

    typedef enum logic [1:0] {
        CMP_OFF_A  = 2'd0,
        CMP_OFF_B  = 2'd1,
        CMP_IF_NE  = 2'd2,
        CMP_IF_EQ  = 2'd3
    } rop_cmp_e;

    localparam int MIX_REG_W = 8;
    localparam int FUNC_W    = 4;
    localparam int SRC_LO    = 5;
endpackage

// File: rtl/rop_src_select.sv
// Source selector: picks the source colour from one of four inputs.
// Assumes the select code follows rop_src_e.
module rop_src_select #(
    parameter int PIX_W = 32
) (
    input  rop_pkg::rop_src_e  sel,
    input  logic [PIX_W-1:0]   bg_color,
    input  logic [PIX_W-1:0]   fg_color,
    input  logic [PIX_W-1:0]   host_data,
    input  logic [PIX_W-1:0]   screen_data,
    output logic [PIX_W-1:0]   src
);
    import rop_pkg::*;

    // Four-way source multiplexer.
    always_comb begin
        unique case (sel)
            SRC_BG:   src = bg_color;
            SRC_FG:   src = fg_color;
            SRC_HOST: src = host_data;
            default:  src = screen_data;
        endcase
    end
endmodule

// File: rtl/rop_mix_alu.sv
// Boolean mix unit: applies one of sixteen bitwise functions to S and D.
// Assumes func is the 4-bit code taken from the active mix register.
module rop_mix_alu #(
    parameter int PIX_W = 32
) (
    input  logic [3:0]        func,
    input  logic [PIX_W-1:0]  s,
    input  logic [PIX_W-1:0]  d,
    output logic [PIX_W-1:0]  y
);
    // Function decode over the whole word.
    always_comb begin
        unique case (func)
            4'h0: y = ~d;
            4'h1: y = '0;
            4'h2: y = '1;
            4'h3: y = d;
            4'h4: y = ~s;
            4'h5: y = s ^ d;
            4'h6: y = ~(s ^ d);
            4'h7: y = s;
            4'h8: y = ~(s & d);
            4'h9: y = ~s | d;
            4'hA: y = s | ~d;
            4'hB: y = s | d;
            4'hC: y = s & d;
            4'hD: y = s & ~d;
            4'hE: y = ~s & d;
            default: y = ~(s | d);
        endcase
    end
endmodule

// File: rtl/rop_cmp_gate.sv
// Colour compare gate: decides whether the pixel may be written.
// Assumes both operands arrive already truncated to the pixel depth.
module rop_cmp_gate #(
    parameter int PIX_W = 32
) (
    input  rop_pkg::rop_cmp_e  mode,
    input  logic [PIX_W-1:0]   src,
    input  logic [PIX_W-1:0]   cmp,
    output logic               pass
);
    import rop_pkg::*;

    logic same;

    // Equality, then mode-dependent pass decision.
    always_comb begin
        same = (src == cmp);
        unique case (mode)
            CMP_IF_NE: pass = !same;
            CMP_IF_EQ: pass = same;
            default:   pass = 1'b1;
        endcase
    end
endmodule

// File: rtl/rop_mono_reduce.sv
// Mono reduction: a screen word becomes 1 when every read-mask bit is set.
// Assumes the mask has already been truncated to the pixel depth.
module rop_mono_reduce #(
    parameter int PIX_W = 32
) (
    input  logic [PIX_W-1:0] data,
    input  logic [PIX_W-1:0] mask,
    output logic             bit_out
);
    logic [PIX_W-1:0] covered;

    // Per-bit coverage: a bit is fine if unmasked or set.
    for (genvar i = 0; i < PIX_W; i++) begin : g_cover
        assign covered[i] = data[i] | ~mask[i];
    end

    // All bits covered gives a mono 1.
    always_comb bit_out = &covered;
endmodule

// File: rtl/rop_pixel_mixer.sv
// Raster-op pixel mixer top: mix selection, source pick, boolean mix,
// compare gate and write-mask merge, registered once.
// Assumes one request per cycle and no back-pressure.
module rop_pixel_mixer #(
    parameter int PIX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mix_bit,
    input  logic             mono_from_screen,
    input  logic [7:0]       fg_mix,
    input  logic [7:0]       bg_mix,
    input  logic [1:0]       cmp_mode,
    input  logic [1:0]       depth,
    input  logic [PIX_W-1:0] fg_color,
    input  logic [PIX_W-1:0] bg_color,
    input  logic [PIX_W-1:0] host_data,
    input  logic [PIX_W-1:0] screen_data,
    input  logic [PIX_W-1:0] dest_data,
    input  logic [PIX_W-1:0] cmp_color,
    input  logic [PIX_W-1:0] write_mask,
    input  logic [PIX_W-1:0] read_mask,
    output logic             out_valid,
    output logic             out_we,
    output logic [PIX_W-1:0] out_data,
    output logic             out_mono
);
    import rop_pkg::*;

    localparam logic [PIX_W-1:0] MASK_8  = PIX_W'({8{1'b1}});
    localparam logic [PIX_W-1:0] MASK_16 = PIX_W'({16{1'b1}});

    logic [PIX_W-1:0]     depth_mask;
    logic                 screen_bit;
    logic                 eff_bit;
    logic [MIX_REG_W-1:0] act_mix;
    logic [PIX_W-1:0]     src;
    logic [PIX_W-1:0]     mixed;
    logic [PIX_W-1:0]     merged;
    logic                 pass;

    // Pixel-depth truncation mask.
    always_comb begin
        unique case (depth)
            2'd0:    depth_mask = MASK_8;
            2'd1:    depth_mask = MASK_16;
            default: depth_mask = '1;
        endcase
    end

    rop_mono_reduce #(.PIX_W(PIX_W)) u_mono (
        .data    (screen_data),
        .mask    (read_mask & depth_mask),
        .bit_out (screen_bit)
    );

    // Effective mix bit and active mix register.
    always_comb begin
        eff_bit = mono_from_screen ? screen_bit : mix_bit;
        act_mix = eff_bit ? fg_mix : bg_mix;
    end

    rop_src_select #(.PIX_W(PIX_W)) u_src (
        .sel         (rop_src_e'(act_mix[SRC_LO+1:SRC_LO])),
        .bg_color    (bg_color),
        .fg_color    (fg_color),
        .host_data   (host_data),
        .screen_data (screen_data),
        .src         (src)
    );

    rop_mix_alu #(.PIX_W(PIX_W)) u_alu (
        .func (act_mix[FUNC_W-1:0]),
        .s    (src),
        .d    (dest_data),
        .y    (mixed)
    );

    rop_cmp_gate #(.PIX_W(PIX_W)) u_cmp (
        .mode (rop_cmp_e'(cmp_mode)),
        .src  (src & depth_mask),
        .cmp  (cmp_color & depth_mask),
        .pass (pass)
    );

    // Write-mask merge against the old destination.
    always_comb merged = (mixed & write_mask) | (dest_data & ~write_mask);

    // Output stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_we    <= 1'b0;
            out_data  <= '0;
            out_mono  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_we    <= in_valid && pass;
            if (in_valid) begin
                out_data <= merged;
                out_mono <= screen_bit;
            end
        end
    end

    AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> out_valid); // R9
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_we)); // R9
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (((out_data ^ $past(dest_data)) & ~$past(write_mask)) == '0)); // R6
    AST_NE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cmp_mode == 2'd2 && ((src ^ cmp_color) & depth_mask) == '0) |=> !out_we); // R5
    AST_EQ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cmp_mode == 2'd3 && ((src ^ cmp_color) & depth_mask) != '0) |=> !out_we); // R5
endmodule

// File: tb/test_rop_pixel_mixer.sv
module test_rop_pixel_mixer;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, mix_bit = 0, mono_from_screen = 0;
    logic [7:0] fg_mix = 0, bg_mix = 0;
    logic [1:0] cmp_mode = 0, depth = 2;
    logic [W-1:0] fg_color = 0, bg_color = 0, host_data = 0, screen_data = 0;
    logic [W-1:0] dest_data = 0, cmp_color = 0, write_mask = '1, read_mask = 0;
    logic out_valid, out_we, out_mono;
    logic [W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rop_pixel_mixer #(.PIX_W(W)) i_rop_pixel_mixer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mix_bit(mix_bit),
        .mono_from_screen(mono_from_screen), .fg_mix(fg_mix), .bg_mix(bg_mix),
        .cmp_mode(cmp_mode), .depth(depth), .fg_color(fg_color), .bg_color(bg_color),
        .host_data(host_data), .screen_data(screen_data), .dest_data(dest_data),
        .cmp_color(cmp_color), .write_mask(write_mask), .read_mask(read_mask),
        .out_valid(out_valid), .out_we(out_we), .out_data(out_data), .out_mono(out_mono)
    );

    // Behavioural reference for one request.
    task automatic model(output bit e_we, output logic [W-1:0] e_data, output bit e_mono);
        logic [W-1:0] dm, s, d, y;
        logic [7:0] m;
        bit b, eq;
        dm = (depth == 0) ? 32'h0000_00FF : (depth == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        e_mono = ((screen_data & read_mask & dm) == (read_mask & dm));
        b = mono_from_screen ? e_mono : mix_bit;
        m = b ? fg_mix : bg_mix;
        case (m[6:5])
            0: s = bg_color;
            1: s = fg_color;
            2: s = host_data;
            default: s = screen_data;
        endcase
        d = dest_data;
        case (m[3:0])
            0: y = ~d;        1: y = 0;          2: y = 32'hFFFF_FFFF; 3: y = d;
            4: y = ~s;        5: y = s ^ d;      6: y = ~(s ^ d);      7: y = s;
            8: y = ~(s & d);  9: y = ~s | d;     10: y = s | ~d;       11: y = s | d;
            12: y = s & d;    13: y = s & ~d;    14: y = ~s & d;       default: y = ~(s | d);
        endcase
        eq = ((s & dm) == (cmp_color & dm));
        e_we = in_valid && !((cmp_mode == 2 && eq) || (cmp_mode == 3 && !eq));
        e_data = (y & write_mask) | (d & ~write_mask);
    endtask

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: predict, clock, compare.
    task automatic step(string tag);
        bit e_we, e_mono, e_v;
        logic [W-1:0] e_data;
        model(e_we, e_data, e_mono);
        e_v = in_valid;
        @(posedge clk);
        #1;
        chk(tag, "out_valid", W'(out_valid), W'(e_v));
        chk(tag, "out_we", W'(out_we), W'(e_we));
        if (e_v) begin
            chk(tag, "out_data", out_data, e_data);
            chk(tag, "out_mono", W'(out_mono), W'(e_mono));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset state, with a request held during reset.
        in_valid = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reset out_valid", W'(out_valid), 0);
        chk("R9", "reset out_we", W'(out_we), 0);
        chk("R9", "reset out_data", out_data, 0);
        chk("R9", "reset out_mono", W'(out_mono), 0);
        rst_n = 1;
        in_valid = 0;
        step("R9");

        fg_color = 32'h1111_2222; bg_color = 32'h3333_4444;
        host_data = 32'h5555_6666; screen_data = 32'h7777_8888;
        dest_data = 32'h0F0F_F0F0; write_mask = '1; in_valid = 1;

        // R1: mix bit picks register (fg source fg, bg source bg).
        fg_mix = 8'h27; bg_mix = 8'h07;
        mix_bit = 1; step("R1");
        mix_bit = 0; step("R1");

        // R2: each source code through function S.
        mix_bit = 1;
        for (int k = 0; k < 4; k++) begin
            fg_mix = {1'b0, 2'(k), 5'h07};
            step("R2");
        end

        // R3 and R4: every function code.
        host_data = 32'hA5A5_F00F; dest_data = 32'h3C3C_0FF0;
        for (int f = 0; f < 8; f++) begin
            fg_mix = 8'h40 | 8'(f); step("R3");
        end
        for (int f = 8; f < 16; f++) begin
            fg_mix = 8'h40 | 8'(f); step("R4");
        end

        // R5: compare modes with equal and unequal colours.
        fg_mix = 8'h47;
        for (int md = 0; md < 4; md++) begin
            cmp_mode = 2'(md);
            cmp_color = host_data; step("R5");
            cmp_color = host_data ^ 32'h0000_0100; step("R5");
        end
        cmp_mode = 0;

        // R6: partial write masks.
        write_mask = 32'hFF00_FF00; step("R6");
        write_mask = 32'h0000_0001; step("R6");
        write_mask = '1;

        // R7: mix bit from screen via read mask.
        mono_from_screen = 1; mix_bit = 0;
        fg_mix = 8'h27; bg_mix = 8'h07;
        read_mask = 32'h0000_0088; screen_data = 32'h0000_00C8; step("R7");
        screen_data = 32'h0000_0048; step("R7");
        read_mask = 0; step("R7");
        mono_from_screen = 0;

        // R8: truncation at 8 and 16 bits.
        depth = 0; fg_mix = 8'h47; host_data = 32'hDEAD_BE5A;
        cmp_mode = 3; cmp_color = 32'h1234_005A; step("R8");
        cmp_mode = 2; step("R8");
        mono_from_screen = 1; read_mask = 32'hFF00_0003; screen_data = 32'h0000_0003;
        step("R8");
        depth = 1; cmp_mode = 3; cmp_color = 32'hFFFF_BE5A; step("R8");
        read_mask = 32'hFF00_0103; screen_data = 32'h0000_0003; step("R8");
        depth = 2; step("R8");
        mono_from_screen = 0; cmp_mode = 0;

        // R9: idle cycles and back-to-back mixed traffic.
        in_valid = 0; step("R9"); step("R9");
        for (int n = 0; n < 400; n++) begin
            in_valid = ($urandom % 4) != 0;
            mix_bit = 1'($urandom); mono_from_screen = 1'($urandom);
            fg_mix = 8'($urandom); bg_mix = 8'($urandom);
            cmp_mode = 2'($urandom); depth = 2'($urandom);
            fg_color = $urandom; bg_color = $urandom; host_data = $urandom;
            screen_data = $urandom; dest_data = $urandom; write_mask = $urandom;
            read_mask = $urandom & $urandom & $urandom;
            cmp_color = (($urandom % 2) == 0) ? host_data : $urandom;
            step("R9");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule